// File: doc/BRIEF.md
# Programmable Parallel Port Group

A 24-line general-purpose digital I/O group behind a byte-wide register bus with four addresses. The lines form three 8-bit ports, A, B and C. Port C is split into two 4-bit halves, and each half has its own direction. A single control word sets all four direction fields at once, but only when its mode-set flag is raised. Each port has an 8-bit output latch that drives the pins. A port read returns the latch for lines that are outputs and the synchronised pin level for lines that are inputs.

Software writes a control word with the mode-set flag to choose directions. That write also clears every output latch. Software then writes the port addresses to drive levels and reads them to sample inputs. After reset every line is an input and nothing is driven. A control write without the mode-set flag is ignored, so a stray write cannot flip directions. Pin inputs cross into the clock domain through a two-stage synchroniser before the read path sees them.

The bus decode is a small selector (`ppg_sel_e`) with four named selections: `SEL_PA`, `SEL_PB`, `SEL_PC` and `SEL_CTRL`. The direction state has one named transition, mode-set. It happens on a control write with bit 7 = 1 and loads the new directions while clearing the latches. Every other access leaves the direction state where it is.

Top module: `ppg_top`

## Requirements
- R1: After reset, `pin_oe` and `pin_out` are all zero, and a read of the control address returns 0x9B (every direction field = input).
- R2: Address 0 selects port A (lines 7..0), address 1 selects port B (lines 15..8), address 2 selects port C (lines 23..16) and address 3 selects the control register.
- R3: On a control write with bit 7 = 1, bit 4 sets port A's direction and bit 1 sets port B's direction (1 = input, `pin_oe` low; 0 = output, `pin_oe` high), visible from the next cycle.
- R4: On the same write, bit 3 sets the direction of port C lines 7..4 (pins 23..20) and bit 0 sets the direction of port C lines 3..0 (pins 19..16), with the same encoding as R3.
- R5: A control write with bit 7 = 0 has no effect: `pin_oe`, `pin_out` and the control readback are unchanged.
- R6: Every control write with bit 7 = 1 clears all three output latches (`pin_out` = 0 the next cycle).
- R7: A write to a port address loads that port's latch from `wdata`, whatever the port's direction, and `pin_out` shows it the next cycle. `pin_out` and `pin_oe` change only on writes.
- R8: A port read returns, bit by bit, the latch value for output lines and the synchronised pin value for input lines.
- R9: A pin change is seen by reads sampled at the third rising edge after the change and later. Reads at the first two edges still return the old level.
- R10: A read of the control address returns 0x80 OR-ed with the four direction bits in positions 4, 3, 1 and 0; bits 6, 5 and 2 read as 0.
- R11: `rdata` is loaded at the rising edge where `rd_en` is high and holds its value otherwise.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr | input | 2 | Register select |
| wr_en | input | 1 | Write strobe, one access per cycle |
| rd_en | input | 1 | Read strobe |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Registered read data |
| pin_in | input | 24 | Pin levels from the pads |
| pin_out | output | 24 | Output latch values to the pads |
| pin_oe | output | 24 | Per-line output enable |

## Verification
The bench sweeps all sixteen combinations of the four direction fields. For each one it loads distinct latch patterns and distinct pin patterns into the three ports, so a read that takes a bit from the wrong source (latch instead of pin) or the wrong port yields a different byte. Each combination is followed by a control write with the mode-set flag clear and inverted direction bits. This tells an ignored write apart from one that is applied. A single rising step on port A pins, read on three consecutive edges, separates a two-stage synchroniser from a shorter or longer one.

// File: rtl/ppg_pkg.sv
package ppg_pkg;

    localparam int unsigned PPG_ADDR_W = 2;
    localparam int unsigned PPG_CW_W   = 8;

    // control word bit positions
    localparam int unsigned CW_MODE_BIT = 7;
    localparam int unsigned CW_A_BIT    = 4;
    localparam int unsigned CW_CH_BIT   = 3;
    localparam int unsigned CW_B_BIT    = 1;
    localparam int unsigned CW_CL_BIT   = 0;

    typedef enum logic [PPG_ADDR_W-1:0] {
        SEL_PA   = 2'd0,
        SEL_PB   = 2'd1,
        SEL_PC   = 2'd2,
        SEL_CTRL = 2'd3
    } ppg_sel_e;

    // 1 = input in every field
    typedef struct packed {
        logic a_in;
        logic b_in;
        logic ch_in;
        logic cl_in;
    } ppg_dir_t;

    localparam ppg_dir_t PPG_DIR_RESET = '{a_in: 1'b1, b_in: 1'b1, ch_in: 1'b1, cl_in: 1'b1};

    function automatic logic [PPG_CW_W-1:0] ppg_pack_cw(input ppg_dir_t d);
        logic [PPG_CW_W-1:0] w;
        w               = '0;
        w[CW_MODE_BIT]  = 1'b1;
        w[CW_A_BIT]     = d.a_in;
        w[CW_CH_BIT]    = d.ch_in;
        w[CW_B_BIT]     = d.b_in;
        w[CW_CL_BIT]    = d.cl_in;
        return w;
    endfunction

endpackage

// File: rtl/ppg_sync.sv
module ppg_sync #(
    parameter int unsigned WIDTH  = 24,
    parameter int unsigned STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);

    logic [STAGES-1:0][WIDTH-1:0] chain;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            chain <= '0;
        end else begin
            chain[0] <= d;
            for (int s = 1; s < int'(STAGES); s++) begin
                chain[s] <= chain[s-1];
            end
        end
    end

    assign q = chain[STAGES-1];

endmodule

// File: rtl/ppg_ctrl.sv
module ppg_ctrl
    import ppg_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  logic     ctrl_wr,
    input  logic     mode_flag,
    input  ppg_dir_t dir_req,
    output ppg_dir_t dir,
    output logic     mode_set
);

    // mode-set transition: only a flagged control write moves the state
    assign mode_set = ctrl_wr & mode_flag;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            dir <= PPG_DIR_RESET;
        end else if (mode_set) begin
            dir <= dir_req;
        end
    end

endmodule

// File: rtl/ppg_latch.sv
module ppg_latch #(
    parameter int unsigned DATA_W    = 8,
    parameter int unsigned NUM_PORTS = 3,
    parameter int unsigned ADDR_W    = 2
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        clr,
    input  logic                        wr,
    input  logic [ADDR_W-1:0]           sel,
    input  logic [DATA_W-1:0]           wdata,
    output logic [NUM_PORTS*DATA_W-1:0] lat
);

    generate
        for (genvar p = 0; p < int'(NUM_PORTS); p++) begin : g_port
            logic [DATA_W-1:0] q;

            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    q <= '0;
                end else if (clr) begin
                    q <= '0;
                end else if (wr && (sel == ADDR_W'(p))) begin
                    q <= wdata;
                end
            end

            assign lat[p*DATA_W +: DATA_W] = q;
        end
    endgenerate

endmodule

// File: rtl/ppg_read.sv
module ppg_read
    import ppg_pkg::*;
#(
    parameter int unsigned DATA_W = 8,
    localparam int unsigned LINES = 3 * DATA_W
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                rd,
    input  ppg_sel_e            sel,
    input  logic [LINES-1:0]    lat,
    input  logic [LINES-1:0]    pin_s,
    input  logic [LINES-1:0]    oe,
    input  logic [PPG_CW_W-1:0] cw,
    output logic [DATA_W-1:0]   rdata
);

    logic [LINES-1:0]  view;
    logic [DATA_W-1:0] nxt;

    assign view = (lat & oe) | (pin_s & ~oe);

    always_comb begin
        unique case (sel)
            SEL_PA:   nxt = view[0*DATA_W +: DATA_W];
            SEL_PB:   nxt = view[1*DATA_W +: DATA_W];
            SEL_PC:   nxt = view[2*DATA_W +: DATA_W];
            SEL_CTRL: nxt = DATA_W'(cw);
            default:  nxt = '0;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rdata <= '0;
        end else if (rd) begin
            rdata <= nxt;
        end
    end

endmodule

// File: rtl/ppg_top.sv
module ppg_top
    import ppg_pkg::*;
#(
    parameter int unsigned DATA_W      = 8,
    parameter int unsigned SYNC_STAGES = 2,
    localparam int unsigned NUM_PORTS  = 3,
    localparam int unsigned LINES      = NUM_PORTS * DATA_W,
    localparam int unsigned NIB        = DATA_W / 2
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [PPG_ADDR_W-1:0] addr,
    input  logic                  wr_en,
    input  logic                  rd_en,
    input  logic [DATA_W-1:0]     wdata,
    output logic [DATA_W-1:0]     rdata,
    input  logic [LINES-1:0]      pin_in,
    output logic [LINES-1:0]      pin_out,
    output logic [LINES-1:0]      pin_oe
);

    ppg_sel_e            sel;
    logic                ctrl_wr;
    logic                port_wr;
    logic                mode_set;
    ppg_dir_t            dir_req;
    ppg_dir_t            dir;
    logic [LINES-1:0]    lat;
    logic [LINES-1:0]    pin_s;
    logic [PPG_CW_W-1:0] cw;

    always_comb begin
        sel     = ppg_sel_e'(addr);
        ctrl_wr = 1'b0;
        port_wr = 1'b0;
        unique case (sel)
            SEL_PA, SEL_PB, SEL_PC: port_wr = wr_en;
            SEL_CTRL:               ctrl_wr = wr_en;
            default:                port_wr = 1'b0;
        endcase
    end

    always_comb begin
        dir_req.a_in  = wdata[CW_A_BIT];
        dir_req.b_in  = wdata[CW_B_BIT];
        dir_req.ch_in = wdata[CW_CH_BIT];
        dir_req.cl_in = wdata[CW_CL_BIT];
    end

    ppg_ctrl u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .ctrl_wr   (ctrl_wr),
        .mode_flag (wdata[CW_MODE_BIT]),
        .dir_req   (dir_req),
        .dir       (dir),
        .mode_set  (mode_set)
    );

    ppg_latch #(
        .DATA_W    (DATA_W),
        .NUM_PORTS (NUM_PORTS),
        .ADDR_W    (PPG_ADDR_W)
    ) u_latch (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (mode_set),
        .wr    (port_wr),
        .sel   (addr),
        .wdata (wdata),
        .lat   (lat)
    );

    ppg_sync #(
        .WIDTH  (LINES),
        .STAGES (SYNC_STAGES)
    ) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (pin_in),
        .q     (pin_s)
    );

    assign cw = ppg_pack_cw(dir);

    // expand direction fields onto lines
    assign pin_oe[0*DATA_W +: DATA_W]       = {DATA_W{~dir.a_in}};
    assign pin_oe[1*DATA_W +: DATA_W]       = {DATA_W{~dir.b_in}};
    assign pin_oe[2*DATA_W +: NIB]          = {NIB{~dir.cl_in}};
    assign pin_oe[2*DATA_W + NIB +: NIB]    = {NIB{~dir.ch_in}};
    assign pin_out = lat;

    ppg_read #(
        .DATA_W (DATA_W)
    ) u_read (
        .clk   (clk),
        .rst_n (rst_n),
        .rd    (rd_en),
        .sel   (sel),
        .lat   (lat),
        .pin_s (pin_s),
        .oe    (pin_oe),
        .cw    (cw),
        .rdata (rdata)
    );

endmodule

// File: rtl/ppg_checker.sv
module ppg_checker #(
    parameter int unsigned DATA_W = 8,
    localparam int unsigned LINES = 3 * DATA_W,
    localparam int unsigned NIB   = DATA_W / 2
) (
    input logic              clk,
    input logic              rst_n,
    input logic [1:0]        addr,
    input logic              wr_en,
    input logic [DATA_W-1:0] wdata,
    input logic [LINES-1:0]  pin_out,
    input logic [LINES-1:0]  pin_oe
);

    always @(negedge clk) begin
        if (!rst_n) begin
            AST_RESET_QUIET: assert (pin_oe == '0 && pin_out == '0); // R1
        end
    end

    AST_MODESET_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == 2'd3 && wdata[7]) |=> (pin_out == '0)); // R6

    AST_PLAIN_CTRL_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == 2'd3 && !wdata[7]) |=> ($stable(pin_oe) && $stable(pin_out))); // R5

    AST_PORT_A_DIR: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == 2'd3 && wdata[7]) |=> (pin_oe[DATA_W-1:0] == {DATA_W{!$past(wdata[4])}})); // R3

    AST_PORT_C_LOW_DIR: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == 2'd3 && wdata[7]) |=> (pin_oe[2*DATA_W +: NIB] == {NIB{!$past(wdata[0])}})); // R4

    AST_PORT_A_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == 2'd0) |=> (pin_out[DATA_W-1:0] == $past(wdata))); // R7

    AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_en) |=> ($stable(pin_out) && $stable(pin_oe))); // R7

endmodule

bind ppg_top ppg_checker u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .addr    (addr),
    .wr_en   (wr_en),
    .wdata   (wdata),
    .pin_out (pin_out),
    .pin_oe  (pin_oe)
);

// File: tb/sim_ppg_top.sv
`timescale 1ns/1ps
module sim_ppg_top;

    logic        clk   = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  addr  = '0;
    logic        wr_en = 1'b0;
    logic        rd_en = 1'b0;
    logic [7:0]  wdata = '0;
    logic [7:0]  rdata;
    logic [23:0] pin_in = '0;
    logic [23:0] pin_out;
    logic [23:0] pin_oe;

    int n_chk = 0;
    int n_err = 0;
    bit done  = 1'b0;

    always #4 clk = ~clk;

    ppg_top u0 (
        .clk     (clk),
        .rst_n   (rst_n),
        .addr    (addr),
        .wr_en   (wr_en),
        .rd_en   (rd_en),
        .wdata   (wdata),
        .rdata   (rdata),
        .pin_in  (pin_in),
        .pin_out (pin_out),
        .pin_oe  (pin_oe)
    );

    task automatic check(input string req, input logic [23:0] act, input logic [23:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic bus_write(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        addr  = a;
        wdata = d;
        wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic bus_read(input logic [1:0] a, output logic [7:0] d);
        @(negedge clk);
        addr  = a;
        rd_en = 1'b1;
        @(negedge clk);
        rd_en = 1'b0;
        d     = rdata;
    endtask

    function automatic logic [23:0] oe_of(input logic [3:0] m);
        // m[3]=A in, m[2]=C high in, m[1]=B in, m[0]=C low in
        return {{4{~m[2]}}, {4{~m[0]}}, {8{~m[1]}}, {8{~m[3]}}};
    endfunction

    function automatic logic [7:0] cw_of(input logic [3:0] m);
        return 8'h80 | {3'b000, m[3], m[2], 1'b0, m[1], m[0]};
    endfunction

    initial begin
        #(8 * 150000);
        if (!done) begin
            n_err++;
            $display("FAIL watchdog: actual running expected finished");
            $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
            $finish;
        end
    end

    initial begin
        logic [7:0]  rd;
        logic [23:0] lat;
        logic [23:0] oe;
        logic [23:0] view;
        logic [7:0]  d0, d1, d2;

        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        check("R1 oe", pin_oe, 24'h0);
        check("R1 out", pin_out, 24'h0);
        bus_read(2'd3, rd);
        check("R1 ctrl", {16'h0, rd}, {16'h0, 8'h9B});

        // R11: rdata holds without strobe
        repeat (3) @(negedge clk);
        check("R11 hold", {16'h0, rdata}, {16'h0, 8'h9B});

        for (int m = 0; m < 16; m++) begin
            logic [3:0] mm;
            mm = 4'(m);
            // preload latches so the clear is visible
            bus_write(2'd0, 8'hFF);
            bus_write(2'd1, 8'hFF);
            bus_write(2'd2, 8'hFF);
            bus_write(2'd3, cw_of(mm));
            oe = oe_of(mm);
            check("R6 clear", pin_out, 24'h0);
            check("R3 R4 oe", pin_oe, oe);
            bus_read(2'd3, rd);
            check("R10 ctrl", {16'h0, rd}, {16'h0, cw_of(mm)});

            lat = {{mm, ~mm}, ~(8'h11 * 8'(m + 1)), 8'h11 * 8'(m + 1)};
            bus_write(2'd0, lat[7:0]);
            bus_write(2'd1, lat[15:8]);
            bus_write(2'd2, lat[23:16]);
            check("R7 R2 latch", pin_out, lat);

            pin_in = {8'(m * 53 + 7), 8'(m * 37 + 90), 8'(m * 11 + 201)};
            repeat (3) @(negedge clk);
            view = (lat & oe) | (pin_in & ~oe);
            bus_read(2'd0, rd);
            check("R8 R2 port A", {16'h0, rd}, {16'h0, view[7:0]});
            bus_read(2'd1, rd);
            check("R8 R2 port B", {16'h0, rd}, {16'h0, view[15:8]});
            bus_read(2'd2, rd);
            check("R8 R2 port C", {16'h0, rd}, {16'h0, view[23:16]});

            // R5: flag clear, direction bits inverted
            bus_write(2'd3, (cw_of(mm) ^ 8'h1B) & 8'h7F);
            check("R5 oe", pin_oe, oe);
            check("R5 out", pin_out, lat);
            bus_read(2'd3, rd);
            check("R5 ctrl", {16'h0, rd}, {16'h0, cw_of(mm)});
        end

        // R9: synchroniser latency, all lines input
        bus_write(2'd3, 8'h9B);
        pin_in = 24'h0;
        repeat (4) @(negedge clk);
        @(negedge clk);
        pin_in = 24'h0000FF;
        addr   = 2'd0;
        rd_en  = 1'b1;
        @(negedge clk);
        d0 = rdata;
        @(negedge clk);
        d1 = rdata;
        @(negedge clk);
        d2 = rdata;
        rd_en = 1'b0;
        check("R9 edge1", {16'h0, d0}, 24'h0);
        check("R9 edge2", {16'h0, d1}, 24'h0);
        check("R9 edge3", {16'h0, d2}, 24'h0000FF);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

endmodule